// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

The block provides eight lock flags that two processor ports, left and right, share for arbitration of common resources. What each flag guards, and what it means to each side, is left to software: a flag can cover a buffer, a register group or a memory region of any size. Each port has its own flag select, write strobe, write data bit, read strobe and read data bit. No access ever stalls a port.

A port asks for a flag by writing a zero to it and then reads that flag back. A read of zero means the port now owns the flag; a read of one means the other port owns it. Writing a one releases an owned flag, or withdraws a request that is still waiting. Every port keeps a request latch per flag. When the owner releases a flag while the other port's latch is still set, ownership moves to the waiting port at that same clock edge, without any further write from it.

Top module: `sem_unit`

## Requirements
- R1: After the active-low asynchronous reset, every flag reads one on both ports and no request is pending.
- R2: A write (wr_i high) with wdata_i = 0 to a free flag gives that port ownership at that clock edge; from the next cycle the port reads zero for that flag.
- R3: While one port owns a flag, the other port reads one for it; the two ports never own the same flag at once.
- R4: A write with wdata_i = 1 by the owner releases the flag at that clock edge; the owner reads one afterwards, and a free flag can then be taken by either port with a single zero write.
- R5: A port whose request is still waiting cancels it by writing one; if the owner later releases, the flag becomes free and both ports read one.
- R6: If both ports write zero to the same free flag on the same clock edge, the left port gets the flag and the right port's request stays pending.
- R7: When the owner releases a flag while the other port's request is pending, the waiting port owns the flag from the next cycle with no further write.
- R8: The 3-bit select picks flag 0 to 7 by its binary value; a write changes only the selected flag, and each port may address a different flag in the same cycle.
- R9: rdata_o follows the selected flag combinationally in the same cycle while rd_i is high (no wait state); with rd_i low, rdata_o is one.
- R10: An owner that writes zero again to its own flag keeps ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_sel_i | input | 3 | Left port flag select |
| l_wr_i | input | 1 | Left port write strobe |
| l_wdata_i | input | 1 | Left port write bit: 0 request, 1 release |
| l_rd_i | input | 1 | Left port read strobe |
| l_rdata_o | output | 1 | Left port read bit: 0 owned by this port |
| r_sel_i | input | 3 | Right port flag select |
| r_wr_i | input | 1 | Right port write strobe |
| r_wdata_i | input | 1 | Right port write bit: 0 request, 1 release |
| r_rd_i | input | 1 | Right port read strobe |
| r_rdata_o | output | 1 | Right port read bit: 0 owned by this port |

## Verification
The bench targets the simultaneous zero write on a free flag, where a design with the wrong tie-break grants the right port or both ports, and the release with a pending request, where a design that drops the latched request leaves the flag free and makes the waiter write again. It also cancels a pending request before the release, which a design that ignores the cancel turns into a grant that nobody asked for. A repeated zero write by the owner and writes that land on neighbouring flags expose designs that reset ownership or decode the select wrongly. A long random run on a few flags then drives every mix of these against a behavioural model that updates queued ownership each clock.

// File: rtl/sem_pkg.sv
package sem_pkg;
  parameter int unsigned SEM_FLAGS = 8;
  localparam int unsigned SEM_SEL_W = $clog2(SEM_FLAGS);

  typedef enum logic {
    PORT_L = 1'b0,
    PORT_R = 1'b1
  } sem_port_e;

  typedef struct packed {
    logic [SEM_SEL_W-1:0] sel;
    logic                 wr;
    logic                 wdata;
    logic                 rd;
  } sem_acc_t;
endpackage

// File: rtl/sem_req_bank.sv
module sem_req_bank #(
  parameter int unsigned N_FLAGS = 8,
  localparam int unsigned SEL_W = $clog2(N_FLAGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               wr_i,
  input  logic               wdata_i,
  output logic [N_FLAGS-1:0] req_d_o,
  output logic [N_FLAGS-1:0] req_q_o
);
  logic [N_FLAGS-1:0] req_q;

  for (genvar f = 0; f < N_FLAGS; f++) begin : g_latch
    logic hit;
    assign hit = wr_i && (sel_i == SEL_W'(f));
    // write 0 asks, write 1 releases or cancels
    assign req_d_o[f] = hit ? ~wdata_i : req_q[f];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_q[f] <= 1'b0;
      else         req_q[f] <= req_d_o[f];
    end
  end

  assign req_q_o = req_q;

  assert_req_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i) |=> req_q[$past(sel_i)]);

  assert_req_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i) |=> !req_q[$past(sel_i)]);

  assert_req_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(req_q));
endmodule

// File: rtl/sem_grant_cell.sv
module sem_grant_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_l_i,
  input  logic req_r_i,
  output logic gnt_l_o,
  output logic gnt_r_o
);
  logic gnt_l_q, gnt_r_q;
  logic gnt_l_d, gnt_r_d;

  // left wins a tie; a holder keeps the flag while its request stays set
  always_comb begin
    gnt_l_d = req_l_i && (gnt_l_q || !(gnt_r_q && req_r_i));
    gnt_r_d = req_r_i && !gnt_l_d && (gnt_r_q || !(gnt_l_q && req_l_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_l_q <= 1'b0;
      gnt_r_q <= 1'b0;
    end else begin
      gnt_l_q <= gnt_l_d;
      gnt_r_q <= gnt_r_d;
    end
  end

  assign gnt_l_o = gnt_l_q;
  assign gnt_r_o = gnt_r_q;

  assert_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gnt_l_q && gnt_r_q));

  assert_tie_left_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt_l_q && !gnt_r_q && req_l_i && req_r_i) |=> (gnt_l_q && !gnt_r_q));

  assert_handoff_l2r_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_l_q && !req_l_i && req_r_i) |=> gnt_r_q);

  assert_handoff_r2l_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_r_q && !req_r_i && req_l_i) |=> gnt_l_q);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_l_q && req_l_i) |=> gnt_l_q);

  assert_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_l_i && !req_r_i) |=> (!gnt_l_q && !gnt_r_q));
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
  parameter int unsigned N_FLAGS = 8,
  localparam int unsigned SEL_W = $clog2(N_FLAGS)
) (
  input  logic [N_FLAGS-1:0] gnt_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               rd_i,
  output logic               rdata_o
);
  // zero only for the port that holds the flag
  assign rdata_o = rd_i ? ~gnt_i[sel_i] : 1'b1;
endmodule

// File: rtl/sem_unit.sv
module sem_unit
  import sem_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SEM_SEL_W-1:0] l_sel_i,
  input  logic                 l_wr_i,
  input  logic                 l_wdata_i,
  input  logic                 l_rd_i,
  output logic                 l_rdata_o,
  input  logic [SEM_SEL_W-1:0] r_sel_i,
  input  logic                 r_wr_i,
  input  logic                 r_wdata_i,
  input  logic                 r_rd_i,
  output logic                 r_rdata_o
);
  sem_acc_t           acc   [2];
  logic [SEM_FLAGS-1:0] req_d [2];
  logic [SEM_FLAGS-1:0] req_q [2];
  logic [SEM_FLAGS-1:0] gnt   [2];
  logic                 rdata [2];

  assign acc[PORT_L] = '{sel: l_sel_i, wr: l_wr_i, wdata: l_wdata_i, rd: l_rd_i};
  assign acc[PORT_R] = '{sel: r_sel_i, wr: r_wr_i, wdata: r_wdata_i, rd: r_rd_i};

  for (genvar p = 0; p < 2; p++) begin : g_port
    sem_req_bank #(.N_FLAGS(SEM_FLAGS)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (acc[p].sel),
      .wr_i    (acc[p].wr),
      .wdata_i (acc[p].wdata),
      .req_d_o (req_d[p]),
      .req_q_o (req_q[p])
    );

    sem_read_port #(.N_FLAGS(SEM_FLAGS)) u_read (
      .gnt_i   (gnt[p]),
      .sel_i   (acc[p].sel),
      .rd_i    (acc[p].rd),
      .rdata_o (rdata[p])
    );
  end

  for (genvar f = 0; f < SEM_FLAGS; f++) begin : g_flag
    sem_grant_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_l_i (req_d[PORT_L][f]),
      .req_r_i (req_d[PORT_R][f]),
      .gnt_l_o (gnt[PORT_L][f]),
      .gnt_r_o (gnt[PORT_R][f])
    );

    assert_gnt_has_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt[PORT_L][f] -> req_q[PORT_L][f]) && (gnt[PORT_R][f] -> req_q[PORT_R][f]));
  end

  assign l_rdata_o = rdata[PORT_L];
  assign r_rdata_o = rdata[PORT_R];

  assert_free_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_wr_i && !l_wdata_i && !gnt[PORT_R][l_sel_i]) |=> gnt[PORT_L][$past(l_sel_i)]);
endmodule

// File: tb/tb_sem_unit.sv
module tb_sem_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] l_sel_i = '0, r_sel_i = '0;
  logic       l_wr_i = 1'b0, l_wdata_i = 1'b1, l_rd_i = 1'b0;
  logic       r_wr_i = 1'b0, r_wdata_i = 1'b1, r_rd_i = 1'b0;
  logic       l_rdata_o, r_rdata_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // model: per flag request bits and owner (0 free, 1 left, 2 right)
  bit m_req_l [8];
  bit m_req_r [8];
  int m_own   [8];

  always #4 clk_i = ~clk_i;

  sem_unit dut (
    .clk_i, .rst_ni,
    .l_sel_i, .l_wr_i, .l_wdata_i, .l_rd_i, .l_rdata_o,
    .r_sel_i, .r_wr_i, .r_wdata_i, .r_rd_i, .r_rdata_o
  );

  task automatic compare(string tag);
    logic exp_l, exp_r;
    exp_l = l_rd_i ? (m_own[l_sel_i] != 1) : 1'b1;
    exp_r = r_rd_i ? (m_own[r_sel_i] != 2) : 1'b1;
    n_cmp += 2;
    if (l_rdata_o !== exp_l) begin
      n_bad++;
      $display("FAIL %s left flag %0d: got %b expected %b", tag, l_sel_i, l_rdata_o, exp_l);
    end
    if (r_rdata_o !== exp_r) begin
      n_bad++;
      $display("FAIL %s right flag %0d: got %b expected %b", tag, r_sel_i, r_rdata_o, exp_r);
    end
  endtask

  task automatic model_edge();
    if (l_wr_i) m_req_l[l_sel_i] = !l_wdata_i;
    if (r_wr_i) m_req_r[r_sel_i] = !r_wdata_i;
    for (int f = 0; f < 8; f++) begin
      if (m_own[f] == 1 && !m_req_l[f]) m_own[f] = m_req_r[f] ? 2 : 0;
      else if (m_own[f] == 2 && !m_req_r[f]) m_own[f] = m_req_l[f] ? 1 : 0;
      if (m_own[f] == 0) begin
        if (m_req_l[f]) m_own[f] = 1;
        else if (m_req_r[f]) m_own[f] = 2;
      end
    end
  endtask

  // one cycle: drive at negedge, check mid-cycle, advance model at posedge
  task automatic cyc(string tag,
                     int ls, bit lw, bit ld, bit lr,
                     int rs, bit rw, bit rdv, bit rr);
    @(negedge clk_i);
    l_sel_i = 3'(ls); l_wr_i = lw; l_wdata_i = ld; l_rd_i = lr;
    r_sel_i = 3'(rs); r_wr_i = rw; r_wdata_i = rdv; r_rd_i = rr;
    #1;
    compare(tag);
    @(posedge clk_i);
    model_edge();
  endtask

  task automatic read_both(string tag, int f);
    cyc(tag, f, 0, 1, 1, f, 0, 1, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int f = 0; f < 8; f++) begin
      m_req_l[f] = 0; m_req_r[f] = 0; m_own[f] = 0;
    end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: all free after reset
    for (int f = 0; f < 8; f++) read_both("R1", f);

    // R2: left takes flag 2; R3: right sees it held
    cyc("R2", 2, 1, 0, 0, 0, 0, 1, 0);
    cyc("R2", 2, 0, 1, 1, 2, 0, 1, 1);
    cyc("R3", 2, 0, 1, 1, 2, 0, 1, 1);
    // R9: no strobe reads one, strobe follows in same cycle
    cyc("R9", 2, 0, 1, 0, 2, 0, 1, 0);
    // R10: owner writes zero again
    cyc("R10", 2, 1, 0, 1, 2, 0, 1, 1);
    cyc("R10", 2, 0, 1, 1, 2, 0, 1, 1);
    // R8: neighbour writes leave flag 2 alone
    cyc("R8", 3, 1, 0, 1, 1, 1, 0, 1);
    cyc("R8", 3, 0, 1, 1, 1, 0, 1, 1);
    read_both("R8", 2);
    cyc("R8", 3, 1, 1, 1, 1, 1, 1, 1);
    read_both("R8", 3);
    read_both("R8", 1);
    // R4: release then right takes with one write
    cyc("R4", 2, 1, 1, 1, 2, 0, 1, 1);
    read_both("R4", 2);
    cyc("R4", 2, 0, 1, 1, 2, 1, 0, 1);
    read_both("R4", 2);
    cyc("R4", 2, 0, 1, 0, 2, 1, 1, 0);
    read_both("R4", 2);

    // R6: tie on flag 5
    cyc("R6", 5, 1, 0, 0, 5, 1, 0, 0);
    read_both("R6", 5);
    // R7: left releases, pending right owns
    cyc("R7", 5, 1, 1, 1, 5, 0, 1, 1);
    read_both("R7", 5);
    read_both("R7", 5);
    // R5: left requests while right holds, cancels, right releases
    cyc("R5", 5, 1, 0, 1, 5, 0, 1, 1);
    read_both("R5", 5);
    cyc("R5", 5, 1, 1, 1, 5, 0, 1, 1);
    cyc("R5", 5, 0, 1, 1, 5, 1, 1, 1);
    read_both("R5", 5);
    read_both("R5", 5);
    // R7 reverse direction: right holds 6, left waits, right releases
    cyc("R7", 0, 0, 1, 0, 6, 1, 0, 0);
    cyc("R7", 6, 1, 0, 1, 6, 0, 1, 1);
    cyc("R7", 6, 0, 1, 1, 6, 1, 1, 1);
    read_both("R7", 6);
    cyc("R7", 6, 1, 1, 1, 6, 0, 1, 1);

    // random mix on four flags, both ports, every pattern
    for (int i = 0; i < 4000; i++) begin
      cyc("R8", int'($urandom_range(4, 7)), 1'($urandom), 1'($urandom), 1'($urandom),
                int'($urandom_range(4, 7)), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    for (int f = 0; f < 8; f++) read_both("R3", f);

    // R1: reset clears held and pending state
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int f = 0; f < 8; f++) begin
      m_req_l[f] = 0; m_req_r[f] = 0; m_own[f] = 0;
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int f = 0; f < 8; f++) read_both("R1", f);
    finish_run();
  end
endmodule